// File: doc/BRIEF.md
# Serial Register Port with Streaming Status Readout

This block is the host-facing end of a chip's register file. An external controller reaches it over a four-wire SPI link: an active-low select, a clock that idles high, a data line from host to chip and a data line back. Each command opens with an address byte whose top bit gives the direction. A write then carries a data byte from the host. A read has the chip return the contents of the addressed register. Toward the internal logic the block offers a plain strobe interface with an address, write data, a read strobe and a read data return.

One address has a special meaning. A read of it takes a snapshot of seven status bytes and streams them back to back, with no gap between bytes. The port stays locked in that stream until the select line goes high. A write of one key value to one address raises a chip-wide reset pulse. The serial lines are brought into the system clock domain through synchronizer chains, so all outputs are registered in that domain.

Top module: `spi_burst_slave`

## Requirements
- R1: When reset is released, `spi_miso_oe`, `spi_miso`, `reg_wr_stb`, `reg_rd_stb` and `soft_rst` are all 0.
- R2: A command byte with bit 7 = 1 followed by a data byte produces one `reg_wr_stb` pulse carrying address = bits 6..0 of the first byte and the data byte. The pulse comes after the 16th rising SCLK edge and not before it.
- R3: A command byte with bit 7 = 0 produces one `reg_rd_stb` pulse with the address after the 8th rising SCLK edge. The next 8 falling edges present `reg_rdata` on `spi_miso`, MSB first.
- R4: Raising `spi_cs_n` part way through a byte abandons the command with no strobe. The next framed command decodes from its first bit.
- R5: While `spi_cs_n` is high, SCLK and MOSI activity produces no strobe, and `spi_miso_oe` and `spi_miso` stay 0.
- R6: A read of address 0x42 captures `burst_data` at the end of the address byte. It then returns the seven bytes of that capture, most significant byte first, on consecutive bytes with no delay, even if `burst_data` changes afterwards.
- R7: After the seventh streamed byte, every further byte in the same frame reads 0x00.
- R8: Once a stream has started, MOSI is ignored until `spi_cs_n` rises: no write strobe, no read strobe, no new stream. The next frame works normally.
- R9: A write of data 0x5A to address 0x3A pulses `soft_rst` together with the write strobe. Any other address or data leaves `soft_rst` low.
- R10: Several commands may follow each other inside one select frame, and each one is decoded in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock from host, idles high |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| reg_wr_stb | output | 1 | One-cycle write request |
| reg_rd_stb | output | 1 | One-cycle read access, for clear-on-read effects |
| reg_addr | output | 7 | Register address of the current command |
| reg_wdata | output | 8 | Write data, valid with `reg_wr_stb` |
| reg_rdata | input | 8 | Read data for `reg_addr`, sampled the cycle after `reg_rd_stb` |
| burst_data | input | 56 | Seven status bytes for the stream, byte 0 in the top bits |
| soft_rst | output | 1 | One-cycle chip-wide reset request |

## Verification
A bit counter that drifts shows up on the very next command: the strobes carry a shifted address, or they fire one edge early or late. The bench catches this in full sweeps over all 128 addresses for writes and for reads. A phase register stuck in the stream state shows up as a missing write strobe in the following frame. A stale or mis-ordered transmit buffer shows up as a wrong byte on MISO within eight falling edges of the capture. Changing `burst_data` during the stream and counting strobes through trailing and lock-breaking bytes exposes early capture and a lost lock.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_WDATA,
        PH_RDATA,
        PH_BURST
    } spi_phase_e;

    typedef struct packed {
        logic              is_write;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [DATA_W-1:0] b);
        cmd_t c;
        c.is_write = b[DATA_W-1];
        c.addr     = b[ADDR_W-1:0];
        return c;
    endfunction

    function automatic logic is_reset_cmd(input logic [ADDR_W-1:0] a,
                                          input logic [DATA_W-1:0] d,
                                          input logic [ADDR_W-1:0] key_a,
                                          input logic [DATA_W-1:0] key_d);
        return (a == key_a) && (d == key_d);
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int              STAGES  = 2,
    parameter int              N       = 3,
    parameter logic [N-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    for (genvar b = 0; b < N; b++) begin : g_bit
        if (STAGES == 1) begin : g_single
            logic sh;
            always_ff @(posedge clk) begin
                if (rst) sh <= RST_VAL[b];
                else     sh <= din[b];
            end
            assign dout[b] = sh;
        end else begin : g_chain
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk) begin
                if (rst) sh <= {STAGES{RST_VAL[b]}};
                else     sh <= {sh[STAGES-2:0], din[b]};
            end
            assign dout[b] = sh[STAGES-1];
        end
    end

endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm import spi_burst_pkg::*; #(
    parameter logic [ADDR_W-1:0] BURST_ADDR = 7'h42,
    parameter logic [ADDR_W-1:0] RST_ADDR   = 7'h3A,
    parameter logic [DATA_W-1:0] RST_KEY    = 8'h5A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              sclk_rise,
    input  logic              mosi_bit,
    output spi_phase_e        phase,
    output logic              wr_stb,
    output logic              rd_stb,
    output logic              burst_go,
    output logic              soft_rst,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata
);

    localparam int               CNT_W    = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-2:0] rx_sr;
    logic [DATA_W-1:0] byte_nx;
    cmd_t              cmd_nx;
    logic              take_bit;
    logic              byte_done;

    assign byte_nx   = {rx_sr, mosi_bit};
    assign cmd_nx    = decode_cmd(byte_nx);
    assign take_bit  = sclk_rise && (phase != PH_BURST);
    assign byte_done = take_bit && (bit_cnt == LAST_BIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_ADDR;
            bit_cnt   <= '0;
            rx_sr     <= '0;
            wr_stb    <= 1'b0;
            rd_stb    <= 1'b0;
            burst_go  <= 1'b0;
            soft_rst  <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
        end else begin
            wr_stb   <= 1'b0;
            rd_stb   <= 1'b0;
            burst_go <= 1'b0;
            soft_rst <= 1'b0;
            if (!cs_act) begin
                phase   <= PH_ADDR;
                bit_cnt <= '0;
                rx_sr   <= '0;
            end else if (take_bit) begin
                rx_sr   <= byte_nx[DATA_W-2:0];
                bit_cnt <= bit_cnt + 1'b1;
                if (byte_done) begin
                    unique case (phase)
                        PH_ADDR: begin
                            reg_addr <= cmd_nx.addr;
                            if (cmd_nx.is_write) begin
                                phase <= PH_WDATA;
                            end else begin
                                rd_stb <= 1'b1;
                                if (cmd_nx.addr == BURST_ADDR) begin
                                    phase    <= PH_BURST;
                                    burst_go <= 1'b1;
                                end else begin
                                    phase <= PH_RDATA;
                                end
                            end
                        end
                        PH_WDATA: begin
                            wr_stb    <= 1'b1;
                            reg_wdata <= byte_nx;
                            soft_rst  <= is_reset_cmd(reg_addr, byte_nx,
                                                      RST_ADDR, RST_KEY);
                            phase     <= PH_ADDR;
                        end
                        PH_RDATA: phase <= PH_ADDR;
                        default:  phase <= PH_BURST;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
    parameter int TXW = 56
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cs_act,
    input  logic           load,
    input  logic [TXW-1:0] load_val,
    input  logic           shift,
    input  logic           idle_fall,
    output logic           miso_bit
);

    logic [TXW-1:0] tx_buf;

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            tx_buf   <= '0;
            miso_bit <= 1'b0;
        end else if (load) begin
            tx_buf <= load_val;
        end else if (shift) begin
            miso_bit <= tx_buf[TXW-1];
            tx_buf   <= {tx_buf[TXW-2:0], 1'b0};
        end else if (idle_fall) begin
            miso_bit <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_burst_slave.sv
module spi_burst_slave import spi_burst_pkg::*; #(
    parameter int                SYNC_STAGES = 2,
    parameter int                BURST_LEN   = 7,
    parameter logic [ADDR_W-1:0] BURST_ADDR  = 7'h42,
    parameter logic [ADDR_W-1:0] RST_ADDR    = 7'h3A,
    parameter logic [DATA_W-1:0] RST_KEY     = 8'h5A
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        spi_cs_n,
    input  logic                        spi_sclk,
    input  logic                        spi_mosi,
    output logic                        spi_miso,
    output logic                        spi_miso_oe,
    output logic                        reg_wr_stb,
    output logic                        reg_rd_stb,
    output logic [ADDR_W-1:0]           reg_addr,
    output logic [DATA_W-1:0]           reg_wdata,
    input  logic [DATA_W-1:0]           reg_rdata,
    input  logic [BURST_LEN*DATA_W-1:0] burst_data,
    output logic                        soft_rst
);

    localparam int TXW = BURST_LEN * DATA_W;

    logic [2:0]     sync_q;
    logic           cs_act;
    logic           sclk_s;
    logic           sclk_q;
    logic           sclk_rise;
    logic           sclk_fall;
    spi_phase_e     phase;
    logic           burst_go;
    logic           tx_shift;
    logic [TXW-1:0] tx_load_val;

    spi_sync #(
        .STAGES  (SYNC_STAGES),
        .N       (3),
        .RST_VAL (3'b011)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({spi_mosi, spi_sclk, spi_cs_n}),
        .dout (sync_q)
    );

    assign cs_act = !sync_q[0];
    assign sclk_s = sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q      <= 1'b1;
            spi_miso_oe <= 1'b0;
        end else begin
            sclk_q      <= sclk_s;
            spi_miso_oe <= cs_act;
        end
    end

    assign sclk_rise = sclk_s && !sclk_q;
    assign sclk_fall = !sclk_s && sclk_q;

    spi_cmd_fsm #(
        .BURST_ADDR (BURST_ADDR),
        .RST_ADDR   (RST_ADDR),
        .RST_KEY    (RST_KEY)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .mosi_bit  (sync_q[2]),
        .phase     (phase),
        .wr_stb    (reg_wr_stb),
        .rd_stb    (reg_rd_stb),
        .burst_go  (burst_go),
        .soft_rst  (soft_rst),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata)
    );

    assign tx_shift    = sclk_fall && (phase == PH_RDATA || phase == PH_BURST);
    assign tx_load_val = burst_go ? burst_data
                                  : {reg_rdata, {(TXW-DATA_W){1'b0}}};

    spi_tx_shift #(
        .TXW (TXW)
    ) u_tx (
        .clk       (clk),
        .rst       (rst),
        .cs_act    (cs_act),
        .load      (reg_rd_stb),
        .load_val  (tx_load_val),
        .shift     (tx_shift),
        .idle_fall (sclk_fall && !tx_shift),
        .miso_bit  (spi_miso)
    );

endmodule

// File: rtl/spi_burst_slave_chk.sv
module spi_burst_slave_chk #(
    parameter int          SYNC_STAGES = 2,
    parameter logic [6:0]  RST_ADDR    = 7'h3A,
    parameter logic [7:0]  RST_KEY     = 8'h5A
) (
    input logic       clk,
    input logic       rst,
    input logic       spi_cs_n,
    input logic       spi_miso,
    input logic       spi_miso_oe,
    input logic       reg_wr_stb,
    input logic       reg_rd_stb,
    input logic [6:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       soft_rst
);

    localparam int QUIET = SYNC_STAGES + 2;

    logic [3:0] cs_hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)                      cs_hi_cnt <= '0;
        else if (!spi_cs_n)           cs_hi_cnt <= '0;
        else if (cs_hi_cnt != 4'hF)   cs_hi_cnt <= cs_hi_cnt + 1'b1;
    end

    // R2: a write request lasts exactly one cycle
    a_r2_wr_pulse: assert property (@(posedge clk) disable iff (rst)
        reg_wr_stb |=> !reg_wr_stb);

    // R3: a read access lasts exactly one cycle
    a_r3_rd_pulse: assert property (@(posedge clk) disable iff (rst)
        reg_rd_stb |=> !reg_rd_stb);

    // R10: one command never yields both kinds of request at once
    a_r10_one_kind: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr_stb && reg_rd_stb));

    // R9: the reset request only accompanies the key write
    a_r9_key_write: assert property (@(posedge clk) disable iff (rst)
        soft_rst |-> (reg_wr_stb && reg_addr == RST_ADDR && reg_wdata == RST_KEY));

    // R5: a deselected port stays silent
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (cs_hi_cnt >= 4'(QUIET)) |-> (!reg_wr_stb && !reg_rd_stb && !spi_miso_oe && !spi_miso));

endmodule

bind spi_burst_slave spi_burst_slave_chk #(
    .SYNC_STAGES (SYNC_STAGES),
    .RST_ADDR    (RST_ADDR),
    .RST_KEY     (RST_KEY)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .spi_cs_n    (spi_cs_n),
    .spi_miso    (spi_miso),
    .spi_miso_oe (spi_miso_oe),
    .reg_wr_stb  (reg_wr_stb),
    .reg_rd_stb  (reg_rd_stb),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .soft_rst    (soft_rst)
);

// File: tb/spi_burst_slave_test.sv
module spi_burst_slave_test;

    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic        miso_oe;
    logic        wr_stb;
    logic        rd_stb;
    logic [6:0]  addr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic [55:0] bdata = '0;
    logic        srst;

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;
    int unsigned wr_cnt = 0, rd_cnt = 0, srst_cnt = 0;
    logic [6:0]  last_wa = '0, last_ra = '0;
    logic [7:0]  last_wd = '0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [7:0] rd_model(input logic [6:0] a);
        return {a[0], a} ^ 8'h3C;
    endfunction

    function automatic logic [7:0] wr_model(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    assign rdata = rd_model(addr);

    spi_burst_slave uut (
        .clk         (clk),
        .rst         (rst),
        .spi_cs_n    (cs_n),
        .spi_sclk    (sclk),
        .spi_mosi    (mosi),
        .spi_miso    (miso),
        .spi_miso_oe (miso_oe),
        .reg_wr_stb  (wr_stb),
        .reg_rd_stb  (rd_stb),
        .reg_addr    (addr),
        .reg_wdata   (wdata),
        .reg_rdata   (rdata),
        .burst_data  (bdata),
        .soft_rst    (srst)
    );

    always @(negedge clk) begin
        if (wr_stb) begin wr_cnt++; last_wa = addr; last_wd = wdata; end
        if (rd_stb) begin rd_cnt++; last_ra = addr; end
        if (srst) srst_cnt++;
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sclk = 1'b0;
            mosi = tx[7-i];
            repeat (HALF) @(negedge clk);
            rx[7-i] = miso;
            sclk = 1'b1;
            repeat (HALF - 1) @(negedge clk);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        send_bits(tx, 8, rx);
    endtask

    task automatic sel;
        @(negedge clk); cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic desel;
        repeat (HALF) @(negedge clk); cs_n = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d);
        logic [7:0] r;
        sel; xfer({1'b1, a}, r); xfer(d, r); desel;
    endtask

    task automatic do_read(input logic [6:0] a, output logic [7:0] d);
        logic [7:0] r;
        sel; xfer({1'b0, a}, r); xfer(8'h00, d); desel;
    endtask

    task automatic burst_case(input logic [55:0] pat);
        logic [7:0] r;
        int unsigned w0, r0;
        bdata = pat;
        sel;
        r0 = rd_cnt;
        xfer(8'h42, r);
        check("R6 burst access strobe", int'(rd_cnt - r0), 1);
        check("R6 burst access addr", int'(last_ra), 8'h42);
        bdata = ~pat;
        for (int k = 0; k < 7; k++) begin
            xfer(8'h00, r);
            check("R6 burst byte", int'(r), int'(pat[55 - 8*k -: 8]));
        end
        w0 = wr_cnt; r0 = rd_cnt;
        xfer(8'hA0, r);
        check("R7 trailing byte zero", int'(r), 0);
        xfer(8'h99, r);
        check("R7 trailing byte zero", int'(r), 0);
        check("R8 write ignored in burst", int'(wr_cnt - w0), 0);
        xfer(8'h42, r);
        check("R8 no second burst", int'(r), 0);
        xfer(8'h05, r);
        check("R8 read ignored in burst", int'(rd_cnt - r0), 0);
        desel;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        int unsigned w0, r0, s0;
        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1 reset state
        check("R1 miso_oe", int'(miso_oe), 0);
        check("R1 miso", int'(miso), 0);
        check("R1 strobes", int'(wr_cnt + rd_cnt + srst_cnt), 0);

        // R5 activity while deselected
        for (int i = 0; i < 4; i++) send_bits(8'hC5 ^ 8'(i), 8, r);
        repeat (4) @(negedge clk);
        check("R5 no strobe while deselected", int'(wr_cnt + rd_cnt), 0);
        check("R5 miso_oe low", int'(miso_oe), 0);
        check("R5 miso low", int'(miso), 0);

        // R2 write sweep over every address
        s0 = srst_cnt;
        for (int a = 0; a < 128; a++) begin
            w0 = wr_cnt;
            do_write(7'(a), wr_model(a));
            check("R2 one write strobe", int'(wr_cnt - w0), 1);
            check("R2 write addr", int'(last_wa), a);
            check("R2 write data", int'(last_wd), int'(wr_model(a)));
        end
        check("R9 no reset from ordinary writes", int'(srst_cnt - s0), 0);

        // R2 strobe timing: nothing after 15 edges, one after the 16th
        w0 = wr_cnt;
        sel;
        xfer(8'h80 | 8'h15, r);
        send_bits(8'hB6, 7, r);
        repeat (6) @(negedge clk);
        check("R2 no strobe before 16th edge", int'(wr_cnt - w0), 0);
        send_bits(8'h00, 1, r);
        repeat (6) @(negedge clk);
        check("R2 strobe after 16th edge", int'(wr_cnt - w0), 1);
        check("R2 timed write data", int'(last_wd), 8'hB6);
        desel;

        // R3 read sweep over every address except the stream address
        for (int a = 0; a < 128; a++) begin
            if (a != 8'h42) begin
                r0 = rd_cnt;
                do_read(7'(a), r);
                check("R3 one read strobe", int'(rd_cnt - r0), 1);
                check("R3 read addr", int'(last_ra), a);
                check("R3 read data on miso", int'(r), int'(rd_model(7'(a))));
            end
        end

        // R3 read strobe after the 8th edge, before any data clocks
        r0 = rd_cnt;
        sel;
        xfer(8'h27, r);
        repeat (6) @(negedge clk);
        check("R3 strobe after address byte", int'(rd_cnt - r0), 1);
        check("R3 miso_oe while selected", int'(miso_oe), 1);
        xfer(8'h00, r);
        check("R3 timed read data", int'(r), int'(rd_model(7'h27)));
        desel;

        // R4 abort inside data byte, then inside address byte
        w0 = wr_cnt;
        sel; xfer(8'h91, r); send_bits(8'hFF, 4, r); desel;
        check("R4 aborted write no strobe", int'(wr_cnt - w0), 0);
        do_read(7'h05, r);
        check("R4 read after abort", int'(r), int'(rd_model(7'h05)));
        r0 = rd_cnt;
        sel; send_bits(8'h0F, 5, r); desel;
        check("R4 aborted address no strobe", int'(rd_cnt - r0), 0);
        do_write(7'h2C, 8'h4E);
        check("R4 write after abort addr", int'(last_wa), 8'h2C);
        check("R4 write after abort data", int'(last_wd), 8'h4E);

        // R6 R7 R8 streams with several patterns
        burst_case(56'h81_FE_02_7F_13_C8_A5);
        burst_case(56'h00_FF_00_FF_55_AA_01);
        burst_case(56'h12_34_56_78_9A_BC_DE);
        do_read(7'h11, r);
        check("R8 port usable after stream", int'(r), int'(rd_model(7'h11)));

        // R9 reset key
        s0 = srst_cnt;
        do_write(7'h3A, 8'h5A);
        check("R9 key write pulses reset", int'(srst_cnt - s0), 1);
        do_write(7'h3A, 8'h5B);
        do_write(7'h3B, 8'h5A);
        check("R9 near misses no reset", int'(srst_cnt - s0), 1);

        // R10 several commands in one frame
        w0 = wr_cnt; r0 = rd_cnt;
        sel;
        xfer(8'h80 | 8'h61, r); xfer(8'h3D, r);
        check("R10 first write addr", int'(last_wa), 8'h61);
        check("R10 first write data", int'(last_wd), 8'h3D);
        xfer(8'h0A, r); xfer(8'h00, r);
        check("R10 read in frame", int'(r), int'(rd_model(7'h0A)));
        xfer(8'h80 | 8'h02, r); xfer(8'hE7, r);
        check("R10 second write data", int'(last_wd), 8'hE7);
        desel;
        check("R10 write count", int'(wr_cnt - w0), 2);
        check("R10 read count", int'(rd_cnt - r0), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule